// File: doc/BRIEF.md
# RC4 Stream Cipher Engine

A byte-wide RC4 unit controlled through a small register window and fed through two byte queues. Software selects a mode, loads up to sixteen key bytes and writes a key length. That write starts a 256-step key schedule that runs one swap per clock. Instead of a key schedule, software may restore a saved permutation. It streams the 259 context bytes into the input queue and then writes the fixed context length of 2072 bits to the size register.

A write of the message length in bits to the same size register starts the cipher. From then on, each clock that has an input byte, room in the output queue and no error takes one byte in and places one byte out. The output byte is the input byte XORed with the next keystream byte. The size register carries the error rules. A length whose low three bits are nonzero raises a size error. A length of zero locks the unit. A write to the register while a message is still in progress raises a context error. All of these flags are sticky, and while any of them is set no output is produced. A reset-control register holds three self-clearing bits: one for a unit reset, one for a queue flush and one for an error clear.

Top module: `rc4_engine`

## Requirements
- R1: After reset the status register (address 5) reads 0, the size register (address 3) reads 0, the output queue is empty and the input queue is not full.
- R2: Key bytes are written at address 1 (slot in bits 11:8, byte in bits 7:0). A key length of 1 to 16 written at address 2 with mode bit 0 of address 0 set starts the key schedule: status bit 0 (busy) is set and status bit 1 (ready) is cleared. Ready is set exactly 256 clocks after that write. A length of 0 or above 16 is ignored.
- R3: A size write at address 3 whose low three bits are zero and which is nonzero (and not a context commit) makes the unit process exactly size/8 bytes. The whole value above bit 2 counts. Each output byte is the input byte XORed with the standard RC4 keystream byte.
- R4: A size write with any of bits 2:0 set sets status bit 2 (size error) and starts nothing.
- R5: A size write of zero sets status bit 4 (lock). The error-clear control bit leaves the lock set. Only a unit reset clears it.
- R6: A size write while bytes of a message are still outstanding sets status bit 3 (context error). The write is discarded.
- R7: While any of status bits 2, 3 or 4 is set, no byte is placed in the output queue.
- R8: With mode bit 0 clear, a size write of 2072 pops 259 input bytes as S[0..255], then i, then j, then one pad byte. It then sets ready, and later messages continue the keystream from that state.
- R9: Processing stalls without loss while the input queue is empty or the output queue is full.
- R10: In the control register at address 4, bit 0 resets the unit, bit 1 flushes both queues and bit 2 clears the size and context errors. Each bit reads back for one clock after the write and then reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| in_push | input | 1 | Push a byte into the input queue |
| in_byte | input | 8 | Byte to push |
| in_full | output | 1 | Input queue full |
| out_pop | input | 1 | Pop the head of the output queue |
| out_byte | output | 8 | Head of the output queue |
| out_empty | output | 1 | Output queue empty |

## Verification
A register write takes effect at the clock edge that samples it. The bench therefore reads status and size at the next falling edge. A control bit acts one edge later, so the bench waits two clocks before it looks at the effects of a reset, a flush or an error clear. The ready bit is polled and its arrival is counted: it must appear 256 clocks after the key-length write. A byte pushed in lands in the output queue one clock after it becomes the input head when the unit is free to run. For that reason, output bytes are compared in order against a bench RC4 model, and the bench does not compare them at fixed cycles. Absence of output under errors is checked after a wait of twenty clocks.

// File: rtl/rc4_pkg.sv
package rc4_pkg;

    localparam int DATA_W     = 32;
    localparam int ADDR_W     = 3;
    localparam int KEY_MAX    = 16;
    localparam int KEY_IDX_W  = $clog2(KEY_MAX);
    localparam int KEY_LEN_W  = $clog2(KEY_MAX + 1);
    localparam int SBOX_N     = 256;
    localparam int CTX_BYTES  = SBOX_N + 3;
    localparam int CTX_BITS   = CTX_BYTES * 8;
    localparam int CTX_CNT_W  = $clog2(CTX_BYTES);
    localparam int NBYTES_W   = DATA_W - 3;
    localparam int IN_DEPTH   = 512;
    localparam int OUT_DEPTH  = 16;

    localparam logic [ADDR_W-1:0] A_MODE   = 3'd0;
    localparam logic [ADDR_W-1:0] A_KEY    = 3'd1;
    localparam logic [ADDR_W-1:0] A_KEYLEN = 3'd2;
    localparam logic [ADDR_W-1:0] A_SIZE   = 3'd3;
    localparam logic [ADDR_W-1:0] A_RSTCTL = 3'd4;
    localparam logic [ADDR_W-1:0] A_STATUS = 3'd5;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_KSA,
        PH_CTX
    } phase_e;

    typedef struct packed {
        logic lock;
        logic ctx_err;
        logic dsize_err;
        logic ready;
        logic busy;
    } status_t;

    typedef struct packed {
        logic                start_ksa;
        logic                start_ctx;
        logic                start_data;
        logic [NBYTES_W-1:0] nbytes;
    } cmd_t;

    function automatic logic size_misaligned(input logic [DATA_W-1:0] v);
        return v[2:0] != 3'd0;
    endfunction

    // Value at index t once S[ni] and S[nj] have been exchanged.
    function automatic logic [7:0] pick_after_swap(
        input logic [7:0] t,
        input logic [7:0] raw,
        input logic [7:0] si,
        input logic [7:0] sj,
        input logic [7:0] ni,
        input logic [7:0] nj
    );
        if (t == nj)
            return si;
        else if (t == ni)
            return sj;
        else
            return raw;
    endfunction

endpackage

// File: rtl/rc4_fifo.sv
module rc4_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic             full
);
    localparam int AW = $clog2(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW:0]      wptr;
    logic [AW:0]      rptr;
    logic             do_push;
    logic             do_pop;

    assign empty   = (wptr == rptr);
    assign full    = (wptr[AW-1:0] == rptr[AW-1:0]) && (wptr[AW] != rptr[AW]);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rptr[AW-1:0]];

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wptr <= '0;
            rptr <= '0;
        end else begin
            if (do_push) begin
                mem[wptr[AW-1:0]] <= din;
                wptr <= wptr + 1'b1;
            end
            if (do_pop)
                rptr <= rptr + 1'b1;
        end
    end

endmodule

// File: rtl/rc4_regs.sv
module rc4_regs
    import rc4_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  reg_wr,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic [DATA_W-1:0]     reg_wdata,
    output logic [DATA_W-1:0]     reg_rdata,
    input  logic                  core_busy,
    input  logic                  core_ready,
    input  logic                  run_active,
    output cmd_t                  cmd,
    output logic [KEY_MAX*8-1:0]  key_bytes,
    output logic [KEY_LEN_W-1:0]  key_len,
    output logic                  halt,
    output logic                  unit_rst,
    output logic                  fifo_flush,
    output logic                  lock_o,
    output logic                  dsize_err_o,
    output logic [2:0]            ctl_o
);
    logic                 mode_q;
    logic [7:0]           key_q [KEY_MAX];
    logic [KEY_LEN_W-1:0] keylen_q;
    logic [DATA_W-1:0]    size_q;
    logic [2:0]           ctl_q;
    logic                 dsize_err;
    logic                 ctx_err;
    logic                 lock;
    logic                 wr_ok;
    logic                 size_wr;
    logic                 len_ok;
    status_t              st;

    generate
        for (genvar g = 0; g < KEY_MAX; g++) begin : g_key
            assign key_bytes[g*8 +: 8] = key_q[g];
        end
    endgenerate

    assign wr_ok   = reg_wr && !ctl_q[0];
    assign size_wr = wr_ok && (reg_addr == A_SIZE);
    assign len_ok  = (reg_wdata[KEY_LEN_W-1:0] != '0)
                  && (reg_wdata[KEY_LEN_W-1:0] <= KEY_LEN_W'(KEY_MAX))
                  && (reg_wdata[DATA_W-1:KEY_LEN_W] == '0);

    always_comb begin
        cmd            = '0;
        cmd.start_ksa  = wr_ok && (reg_addr == A_KEYLEN) && len_ok && mode_q;
        cmd.start_ctx  = size_wr && !run_active && !mode_q
                      && (reg_wdata == DATA_W'(CTX_BITS));
        cmd.start_data = size_wr && !run_active && (reg_wdata != '0)
                      && !size_misaligned(reg_wdata) && !cmd.start_ctx;
        cmd.nbytes     = reg_wdata[DATA_W-1:3];
    end

    always_ff @(posedge clk) begin
        if (rst || ctl_q[0]) begin
            mode_q    <= 1'b0;
            keylen_q  <= '0;
            size_q    <= '0;
            ctl_q     <= '0;
            dsize_err <= 1'b0;
            ctx_err   <= 1'b0;
            lock      <= 1'b0;
            for (int n = 0; n < KEY_MAX; n++)
                key_q[n] <= '0;
        end else begin
            ctl_q <= '0;
            if (ctl_q[2]) begin
                dsize_err <= 1'b0;
                ctx_err   <= 1'b0;
            end
            if (wr_ok) begin
                case (reg_addr)
                    A_MODE:   mode_q <= reg_wdata[0];
                    A_KEY:    key_q[reg_wdata[8 +: KEY_IDX_W]] <= reg_wdata[7:0];
                    A_KEYLEN: if (len_ok) keylen_q <= reg_wdata[KEY_LEN_W-1:0];
                    A_SIZE: begin
                        if (run_active) begin
                            ctx_err <= 1'b1;
                        end else begin
                            size_q <= reg_wdata;
                            if (reg_wdata == '0)
                                lock <= 1'b1;
                            else if (size_misaligned(reg_wdata))
                                dsize_err <= 1'b1;
                        end
                    end
                    A_RSTCTL: ctl_q <= reg_wdata[2:0];
                    default: ;
                endcase
            end
        end
    end

    assign st = '{lock: lock, ctx_err: ctx_err, dsize_err: dsize_err,
                  ready: core_ready, busy: core_busy};

    always_comb begin
        case (reg_addr)
            A_MODE:   reg_rdata = DATA_W'(mode_q);
            A_KEYLEN: reg_rdata = DATA_W'(keylen_q);
            A_SIZE:   reg_rdata = size_q;
            A_RSTCTL: reg_rdata = DATA_W'(ctl_q);
            A_STATUS: reg_rdata = DATA_W'(st);
            default:  reg_rdata = '0;
        endcase
    end

    assign key_len     = keylen_q;
    assign halt        = lock || dsize_err || ctx_err;
    assign unit_rst    = ctl_q[0];
    assign fifo_flush  = ctl_q[1];
    assign lock_o      = lock;
    assign dsize_err_o = dsize_err;
    assign ctl_o       = ctl_q;

endmodule

// File: rtl/rc4_core.sv
module rc4_core
    import rc4_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  cmd_t                 cmd,
    input  logic [KEY_MAX*8-1:0] key_bytes,
    input  logic [KEY_LEN_W-1:0] key_len,
    input  logic                 halt,
    input  logic [7:0]           in_byte,
    input  logic                 in_empty,
    output logic                 in_pop,
    input  logic                 out_full,
    output logic                 out_push,
    output logic [7:0]           out_byte,
    output logic                 ready,
    output logic                 busy,
    output logic                 run_active
);
    logic [7:0]           sbox [SBOX_N];
    phase_e               phase;
    logic [7:0]           pi;
    logic [7:0]           pj;
    logic [7:0]           k;
    logic [KEY_IDX_W-1:0] kidx;
    logic [CTX_CNT_W-1:0] ccnt;
    logic [NBYTES_W-1:0]  remaining;

    // key schedule datapath
    logic [7:0] ksa_si;
    logic [7:0] ksa_key;
    logic [7:0] ksa_j;
    logic [7:0] ksa_sj;
    logic       kidx_last;

    // keystream datapath
    logic [7:0] ni;
    logic [7:0] nj;
    logic [7:0] si;
    logic [7:0] sj;
    logic [7:0] t;
    logic [7:0] ks;
    logic       step;
    logic       ctx_pop;

    assign ksa_si    = sbox[k];
    assign ksa_key   = key_bytes[{kidx, 3'b000} +: 8];
    assign ksa_j     = pj + ksa_si + ksa_key;
    assign ksa_sj    = sbox[ksa_j];
    assign kidx_last = (KEY_LEN_W'(kidx) == key_len - KEY_LEN_W'(1));

    assign ni = pi + 8'd1;
    assign si = sbox[ni];
    assign nj = pj + si;
    assign sj = sbox[nj];
    assign t  = si + sj;
    assign ks = pick_after_swap(t, sbox[t], si, sj, ni, nj);

    assign run_active = (remaining != '0);
    assign step       = (phase == PH_IDLE) && ready && run_active && !in_empty
                     && !out_full && !halt && !cmd.start_ksa && !cmd.start_ctx;
    assign ctx_pop    = (phase == PH_CTX) && !in_empty;
    assign in_pop     = step || ctx_pop;
    assign out_push   = step;
    assign out_byte   = in_byte ^ ks;
    assign busy       = (phase != PH_IDLE) || run_active;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            ready     <= 1'b0;
            pi        <= '0;
            pj        <= '0;
            k         <= '0;
            kidx      <= '0;
            ccnt      <= '0;
            remaining <= '0;
            for (int n = 0; n < SBOX_N; n++)
                sbox[n] <= 8'(n);
        end else begin
            if (cmd.start_data)
                remaining <= cmd.nbytes;
            else if (step)
                remaining <= remaining - 1'b1;

            case (phase)
                PH_IDLE: begin
                    if (cmd.start_ksa) begin
                        phase <= PH_KSA;
                        ready <= 1'b0;
                        k     <= '0;
                        kidx  <= '0;
                        pj    <= '0;
                        for (int n = 0; n < SBOX_N; n++)
                            sbox[n] <= 8'(n);
                    end else if (cmd.start_ctx) begin
                        phase <= PH_CTX;
                        ready <= 1'b0;
                        ccnt  <= '0;
                    end else if (step) begin
                        sbox[ni] <= sj;
                        sbox[nj] <= si;
                        pi       <= ni;
                        pj       <= nj;
                    end
                end
                PH_KSA: begin
                    sbox[k]     <= ksa_sj;
                    sbox[ksa_j] <= ksa_si;
                    pj          <= ksa_j;
                    k           <= k + 8'd1;
                    kidx        <= kidx_last ? '0 : kidx + 1'b1;
                    if (k == 8'(SBOX_N - 1)) begin
                        phase <= PH_IDLE;
                        ready <= 1'b1;
                        pi    <= '0;
                        pj    <= '0;
                    end
                end
                PH_CTX: begin
                    if (ctx_pop) begin
                        ccnt <= ccnt + 1'b1;
                        if (ccnt < CTX_CNT_W'(SBOX_N))
                            sbox[ccnt[7:0]] <= in_byte;
                        else if (ccnt == CTX_CNT_W'(SBOX_N))
                            pi <= in_byte;
                        else if (ccnt == CTX_CNT_W'(SBOX_N + 1))
                            pj <= in_byte;
                        if (ccnt == CTX_CNT_W'(CTX_BYTES - 1)) begin
                            phase <= PH_IDLE;
                            ready <= 1'b1;
                        end
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/rc4_engine.sv
module rc4_engine
    import rc4_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        in_push,
    input  logic [7:0]  in_byte,
    output logic        in_full,
    input  logic        out_pop,
    output logic [7:0]  out_byte,
    output logic        out_empty
);
    cmd_t                 cmd_w;
    logic [KEY_MAX*8-1:0] key_bytes_w;
    logic [KEY_LEN_W-1:0] key_len_w;
    logic                 halt_w;
    logic                 unit_rst_w;
    logic                 flush_w;
    logic                 lock_w;
    logic                 dsize_err_w;
    logic [2:0]           ctl_w;
    logic                 core_busy_w;
    logic                 core_ready_w;
    logic                 run_active_w;
    logic                 blk_rst;
    logic [7:0]           in_head_w;
    logic                 in_empty_w;
    logic                 in_pop_w;
    logic                 out_full_w;
    logic                 out_push_w;
    logic [7:0]           out_data_w;

    assign blk_rst = rst || unit_rst_w;

    rc4_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .core_busy  (core_busy_w),
        .core_ready (core_ready_w),
        .run_active (run_active_w),
        .cmd        (cmd_w),
        .key_bytes  (key_bytes_w),
        .key_len    (key_len_w),
        .halt       (halt_w),
        .unit_rst   (unit_rst_w),
        .fifo_flush (flush_w),
        .lock_o     (lock_w),
        .dsize_err_o(dsize_err_w),
        .ctl_o      (ctl_w)
    );

    rc4_fifo #(.WIDTH(8), .DEPTH(IN_DEPTH)) u_in_q (
        .clk  (clk),
        .rst  (blk_rst),
        .flush(flush_w),
        .push (in_push),
        .din  (in_byte),
        .pop  (in_pop_w),
        .dout (in_head_w),
        .empty(in_empty_w),
        .full (in_full)
    );

    rc4_core u_core (
        .clk       (clk),
        .rst       (blk_rst),
        .cmd       (cmd_w),
        .key_bytes (key_bytes_w),
        .key_len   (key_len_w),
        .halt      (halt_w),
        .in_byte   (in_head_w),
        .in_empty  (in_empty_w),
        .in_pop    (in_pop_w),
        .out_full  (out_full_w),
        .out_push  (out_push_w),
        .out_byte  (out_data_w),
        .ready     (core_ready_w),
        .busy      (core_busy_w),
        .run_active(run_active_w)
    );

    rc4_fifo #(.WIDTH(8), .DEPTH(OUT_DEPTH)) u_out_q (
        .clk  (clk),
        .rst  (blk_rst),
        .flush(flush_w),
        .push (out_push_w),
        .din  (out_data_w),
        .pop  (out_pop),
        .dout (out_byte),
        .empty(out_empty),
        .full (out_full_w)
    );

endmodule

// File: rtl/rc4_engine_chk.sv
module rc4_engine_chk
    import rc4_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        halt_w,
    input logic        out_push_w,
    input logic        out_full_w,
    input logic        lock_w,
    input logic        dsize_err_w,
    input logic [2:0]  ctl_w,
    input logic        run_active_w,
    input logic        reg_wr,
    input logic [2:0]  reg_addr,
    input logic [31:0] reg_wdata
);
    a_r7_no_output_when_halted: assert property (@(posedge clk) disable iff (rst)
        halt_w |-> !out_push_w);

    a_r9_no_push_into_full: assert property (@(posedge clk) disable iff (rst)
        out_push_w |-> !out_full_w);

    a_r5_lock_sticky: assert property (@(posedge clk) disable iff (rst)
        (lock_w && !ctl_w[0]) |=> lock_w);

    a_r10_ctl_self_clears: assert property (@(posedge clk) disable iff (rst)
        (ctl_w != 3'd0 && !(reg_wr && reg_addr == A_RSTCTL)) |=> (ctl_w == 3'd0));

    a_r4_misaligned_flags: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == A_SIZE && reg_wdata[2:0] != 3'd0
         && !run_active_w && !ctl_w[0]) |=> dsize_err_w);
endmodule

bind rc4_engine rc4_engine_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .halt_w      (halt_w),
    .out_push_w  (out_push_w),
    .out_full_w  (out_full_w),
    .lock_w      (lock_w),
    .dsize_err_w (dsize_err_w),
    .ctl_w       (ctl_w),
    .run_active_w(run_active_w),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata)
);

// File: tb/rc4_engine_tb.sv
module rc4_engine_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        in_push = 1'b0;
    logic [7:0]  in_byte = '0;
    logic        in_full;
    logic        out_pop = 1'b0;
    logic [7:0]  out_byte;
    logic        out_empty;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    int         ms [256];
    int         mi;
    int         mj;
    logic [7:0] kbuf [16];
    logic [7:0] din  [64];
    logic [7:0] dexp [64];

    rc4_engine u_dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .in_push(in_push),
        .in_byte(in_byte), .in_full(in_full), .out_pop(out_pop),
        .out_byte(out_byte), .out_empty(out_empty)
    );

    always #4 clk = ~clk;

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=hung expected=finished");
            summary();
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    function automatic void m_ksa(input int len);
        int j = 0;
        for (int n = 0; n < 256; n++) ms[n] = n;
        for (int n = 0; n < 256; n++) begin
            int tmp;
            j = (j + ms[n] + int'(kbuf[n % len])) & 255;
            tmp = ms[n]; ms[n] = ms[j]; ms[j] = tmp;
        end
        mi = 0;
        mj = 0;
    endfunction

    function automatic logic [7:0] m_next();
        int tmp;
        mi = (mi + 1) & 255;
        mj = (mj + ms[mi]) & 255;
        tmp = ms[mi]; ms[mi] = ms[mj]; ms[mj] = tmp;
        return 8'(ms[(ms[mi] + ms[mj]) & 255]);
    endfunction

    // ---------------- bus tasks ----------------
    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic idle(input int n);
        for (int c = 0; c < n; c++) @(negedge clk);
    endtask

    task automatic push_byte(input logic [7:0] b);
        @(negedge clk);
        in_push = 1'b1; in_byte = b;
        @(negedge clk);
        in_push = 1'b0;
    endtask

    task automatic wait_ready(input string tag, output int n);
        logic [31:0] v;
        n = 0;
        rd(3'd5, v);
        while (!v[1] && n < 1000) begin
            @(negedge clk);
            n++;
            rd(3'd5, v);
        end
        chk(tag, 32'(v[1]), 32'd1);
    endtask

    task automatic load_key(input int len, input string tag);
        int n;
        wr(3'd0, 32'd1);
        for (int s = 0; s < len; s++) wr(3'd1, {20'd0, 4'(s), kbuf[s]});
        wr(3'd2, 32'(len));
        wait_ready(tag, n);
        m_ksa(len);
    endtask

    // stream n bytes from din, compare against dexp; hold delays popping
    task automatic stream(input int n, input int hold, input string tag);
        int pushed = 0;
        int popped = 0;
        int c = 0;
        while (popped < n && c < 3000) begin
            @(negedge clk);
            in_push = 1'b0;
            out_pop = 1'b0;
            if (pushed < n && !in_full) begin
                in_push = 1'b1; in_byte = din[pushed]; pushed++;
            end
            if (c >= hold && !out_empty) begin
                chk(tag, 32'(out_byte), 32'(dexp[popped]));
                out_pop = 1'b1;
                popped++;
            end
            c++;
        end
        @(negedge clk);
        in_push = 1'b0;
        out_pop = 1'b0;
        chk({tag, " count"}, 32'(popped), 32'(n));
    endtask

    function automatic void prep(input int n);
        for (int b = 0; b < n; b++) begin
            din[b]  = 8'($urandom);
            dexp[b] = din[b] ^ m_next();
        end
    endfunction

    initial begin
        logic [31:0] v;
        int n;
        void'($urandom(32'd20240611));
        idle(3);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(3'd5, v); chk("R1 status", v, 32'd0);
        rd(3'd3, v); chk("R1 size", v, 32'd0);
        chk("R1 out_empty", 32'(out_empty), 32'd1);
        chk("R1 in_full", 32'(in_full), 32'd0);

        // R2 out-of-range key lengths are ignored
        wr(3'd0, 32'd1);
        wr(3'd2, 32'd17);
        rd(3'd5, v); chk("R2 len17 ignored", v, 32'd0);
        wr(3'd2, 32'd0);
        rd(3'd5, v); chk("R2 len0 ignored", v, 32'd0);

        // R2/R3 known vector: key "Key", text "Pla"
        kbuf[0] = 8'h4B; kbuf[1] = 8'h65; kbuf[2] = 8'h79;
        for (int s = 0; s < 3; s++) wr(3'd1, {20'd0, 4'(s), kbuf[s]});
        wr(3'd2, 32'd3);
        rd(3'd5, v); chk("R2 busy during schedule", v, 32'd1);
        wait_ready("R2 ready", n);
        chk("R2 schedule length", 32'(n), 32'd256);
        m_ksa(3);
        din[0] = 8'h50; din[1] = 8'h6C; din[2] = 8'h61;
        dexp[0] = 8'hBB; dexp[1] = 8'hF3; dexp[2] = 8'h16;
        for (int b = 0; b < 3; b++) void'(m_next());
        wr(3'd3, 32'd24);
        stream(3, 0, "R3 known vector");

        // R4 misaligned size, R7 no output while flagged
        wr(3'd3, 32'd12);
        rd(3'd5, v); chk("R4 size error flag", 32'(v[2]), 32'd1);
        push_byte(8'h11); push_byte(8'h22);
        idle(20);
        chk("R7 no output on size error", 32'(out_empty), 32'd1);
        wr(3'd4, 32'd4);
        idle(2);
        rd(3'd5, v); chk("R10 error clear", 32'(v[2]), 32'd0);
        wr(3'd4, 32'd2);
        idle(2);

        // R3 random keys and lengths, R9 stall on full output
        for (int it = 0; it < 6; it++) begin
            int len = 1 + ($urandom % 16);
            int nb = (it == 5) ? 24 : 1 + ($urandom % 40);
            for (int s = 0; s < len; s++) kbuf[s] = 8'($urandom);
            load_key(len, "R2 random ready");
            prep(nb);
            wr(3'd3, 32'(nb * 8));
            stream(nb, (it == 5) ? 60 : 0, (it == 5) ? "R9 stall" : "R3 random");
        end

        // R10 flush and self-clearing readback
        push_byte(8'hAA); push_byte(8'hBB); push_byte(8'hCC);
        wr(3'd4, 32'd2);
        rd(3'd4, v); chk("R10 ctl visible", v, 32'd2);
        @(negedge clk);
        rd(3'd4, v); chk("R10 ctl self-clear", v, 32'd0);
        idle(1);
        prep(1);
        wr(3'd3, 32'd8);
        stream(1, 0, "R10 flushed");

        // R8 context restore of the model state after a unit reset
        wr(3'd4, 32'd1);
        idle(2);
        rd(3'd5, v); chk("R10 unit reset", v, 32'd0);
        for (int s = 0; s < 256; s++) push_byte(8'(ms[s]));
        push_byte(8'(mi)); push_byte(8'(mj)); push_byte(8'h00);
        wr(3'd3, 32'd2072);
        wait_ready("R8 context ready", n);
        prep(12);
        wr(3'd3, 32'd96);
        stream(12, 0, "R8 restored stream");

        // R6 rewrite during processing
        prep(2);
        wr(3'd3, 32'd64);
        push_byte(din[0]); push_byte(din[1]);
        idle(10);
        for (int b = 0; b < 2; b++) begin
            chk("R6 partial out", 32'(out_byte), 32'(dexp[b]));
            out_pop = 1'b1;
            @(negedge clk);
            out_pop = 1'b0;
        end
        wr(3'd3, 32'd8);
        rd(3'd5, v); chk("R6 context error flag", 32'(v[3]), 32'd1);
        rd(3'd3, v); chk("R6 size kept", v, 32'd64);
        push_byte(8'h01); push_byte(8'h02); push_byte(8'h03);
        idle(20);
        chk("R7 no output on context error", 32'(out_empty), 32'd1);
        wr(3'd4, 32'd1);
        idle(2);

        // R5 lock
        wr(3'd3, 32'd0);
        rd(3'd5, v); chk("R5 lock set", 32'(v[4]), 32'd1);
        wr(3'd4, 32'd4);
        idle(2);
        rd(3'd5, v); chk("R5 lock survives error clear", 32'(v[4]), 32'd1);
        wr(3'd4, 32'd1);
        idle(2);
        rd(3'd5, v); chk("R5 unit reset clears lock", v, 32'd0);

        summary();
    end

endmodule